// File: doc/BRIEF.md
# Time-Shared Montgomery Modular Multiplier

This block returns the 16-bit Montgomery product a·b·R⁻¹ mod N, where R = 2^16, and does it with a single pipelined 16×16 multiplier. The multiplier is used three times in a row. The first pass forms the full product T = a·b. The second forms the reduction factor q = (T mod R)·N' mod R. The third forms the correction q·N. A one-hot ring of state flops drives the multiplier operands and stores each product in a register of its own. After the third product, a final step adds T and q·N, shifts the sum right by 16 and subtracts N once when needed.

The modulus N and the constant N' = −N⁻¹ mod R are fixed at elaboration. A caller pulses `start_i` while the block is idle, with `a_i` and `b_i` both less than N. After a fixed latency the block updates `result_o` and raises `done_o` for one cycle. A new operation may start on the cycle right after `done_o`.

Top module: `mont_mul16`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it goes high, `done_o` is 0 and `result_o` is 0.
- R2: For operands a, b < N, the value in `result_o` when `done_o` is high equals a·b·2^-16 mod N.
- R3: `done_o` is high for exactly one cycle. It rises on the 14th rising edge counted from, and including, the edge that samples an accepted `start_i`.
- R4: A `start_i` pulse while an operation is running is ignored. It produces no extra `done_o` pulse and does not alter the result of the running operation.
- R5: `result_o` changes only on the edge that raises `done_o`, and holds its value otherwise.
- R6: Boundary operands give exact results: any operand equal to 0 gives 0, and the operands 1 and N−1 give the modular value defined in R2.
- R7: Every result is fully reduced, so `result_o` < N.
- R8: The default constants satisfy N·N' ≡ −1 (mod 2^16), with N = 11 and N' = 29789.
- R9: A `start_i` sampled on the edge right after `done_o` is accepted, which gives back-to-back operations with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| a_i | input | 16 | First operand, less than N |
| b_i | input | 16 | Second operand, less than N |
| result_o | output | 16 | Montgomery product, held between operations |
| done_o | output | 1 | One-cycle pulse when result_o updates |

## Verification
The bench runs operations back to back, using random operands and the operands 0, 1 and N−1. A sequencer that captured a product one cycle early or late would store a pipeline value that is still in flight, and would give wrong products even for 1·1. A missing final subtraction gives results of N or more. A subtraction that fires when it should not gives wrong results near N−1. A start pulse injected in the middle of an operation catches a ring that restarts or accepts a new operation while busy, because that shows up as a corrupted result or an unexpected extra done. The start-to-done cycle count is checked on every operation, so any change to the latency is caught.

// File: rtl/mont_pkg.sv
package mont_pkg;
  // ring layout: idle, then per product (stages waits + capture), then finish
  function automatic int ring_len(input int stages);
    return 3 * (stages + 1) + 2;
  endfunction

  function automatic int cap_idx(input int k, input int stages);
    return k * (stages + 1) + stages + 1;
  endfunction

  function automatic int fin_idx(input int stages);
    return 3 * (stages + 1) + 1;
  endfunction
endpackage

// File: rtl/mont_mul_pipe.sv
module mont_mul_pipe #(
  parameter int W      = 16,
  parameter int STAGES = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [2*W-1:0] p_o
);
  logic [2*W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= x_i * y_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= '0;
      else         pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign p_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mont_seq_ring.sv
module mont_seq_ring #(
  parameter int NST = 14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output logic [NST-1:0] state_o
);
  logic [NST-1:0] state_q, state_d;

  // bit 0 is idle: hold there until start, otherwise rotate by one
  always_comb begin
    if (state_q[0] && !start_i) state_d = state_q;
    else                        state_d = {state_q[NST-2:0], state_q[NST-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= NST'(1);
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mont_reduce.sv
module mont_reduce #(
  parameter int W     = 16,
  parameter int MOD_N = 11
) (
  input  logic [2*W-1:0] t_i,
  input  logic [2*W-1:0] qn_i,
  output logic [W-1:0]   res_o
);
  logic [2*W:0] sum;
  logic [W:0]   shifted;
  logic [W:0]   minus_n;

  assign sum     = {1'b0, t_i} + {1'b0, qn_i};
  assign shifted = sum[2*W:W];
  assign minus_n = shifted - (W+1)'(MOD_N);
  assign res_o   = (shifted >= (W+1)'(MOD_N)) ? minus_n[W-1:0] : shifted[W-1:0];
endmodule

// File: rtl/mont_mul16.sv
module mont_mul16 #(
  parameter int W          = 16,
  parameter int MOD_N      = 11,
  parameter int MOD_NINV   = 29789,
  parameter int MUL_STAGES = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  import mont_pkg::*;

  localparam int NST   = ring_len(MUL_STAGES);
  localparam int S_CT  = cap_idx(0, MUL_STAGES);
  localparam int S_CQ  = cap_idx(1, MUL_STAGES);
  localparam int S_CQN = cap_idx(2, MUL_STAGES);
  localparam int S_FIN = fin_idx(MUL_STAGES);

  logic [NST-1:0] state_q;
  logic [W-1:0]   op_x_q, op_y_q;
  logic [2*W-1:0] prod;
  logic [2*W-1:0] prod_t_q, prod_q_q, prod_qn_q;
  logic [W-1:0]   red;
  logic [W-1:0]   result_q;
  logic           done_q;

  mont_seq_ring #(.NST(NST)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .state_o(state_q)
  );

  mont_mul_pipe #(.W(W), .STAGES(MUL_STAGES)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_i   (op_x_q),
    .y_i   (op_y_q),
    .p_o   (prod)
  );

  mont_reduce #(.W(W), .MOD_N(MOD_N)) u_red (
    .t_i  (prod_t_q),
    .qn_i (prod_qn_q),
    .res_o(red)
  );

  // one bit per action, no priority between states
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_x_q    <= '0;
      op_y_q    <= '0;
      prod_t_q  <= '0;
      prod_q_q  <= '0;
      prod_qn_q <= '0;
      result_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (1'b1)
        state_q[0]: begin
          if (start_i) begin
            op_x_q <= a_i;
            op_y_q <= b_i;
          end
        end
        state_q[S_CT]: begin
          prod_t_q <= prod;
          op_x_q   <= prod[W-1:0];
          op_y_q   <= W'(MOD_NINV);
        end
        state_q[S_CQ]: begin
          prod_q_q <= prod;
          op_x_q   <= prod[W-1:0];
          op_y_q   <= W'(MOD_N);
        end
        state_q[S_CQN]: prod_qn_q <= prod;
        state_q[S_FIN]: begin
          result_q <= red;
          done_q   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/mont_mul16_chk.sv
module mont_mul16_chk #(
  parameter int W     = 16,
  parameter int MOD_N = 11,
  parameter int NST   = 14
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           done_i,
  input logic [W-1:0]   result_i,
  input logic [NST-1:0] state_i
);
  logic [7:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (state_i[0] && start_i) cnt_q <= 8'd1;
    else if (done_i)               cnt_q <= '0;
    else if (cnt_q != 0)           cnt_q <= cnt_q + 8'd1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R3
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (cnt_q == 8'(NST))); // R3
  AST_RESULT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (result_i < W'(MOD_N))); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(result_i)); // R5
  AST_RING_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_i) == 1); // R4
endmodule

bind mont_mul16 mont_mul16_chk #(.W(W), .MOD_N(MOD_N), .NST(NST)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_i  (done_o),
  .result_i(result_o),
  .state_i (state_q)
);

// File: tb/mont_mul16_bench.sv
module mont_mul16_bench;
  localparam int W    = 16;
  localparam int N    = 11;
  localparam int NINV = 29789;
  localparam int LAT  = 14;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] result_o;
  logic         done_o;

  int n_run = 0, n_fail = 0;
  longint cyc = 0;
  int rinv = 0;

  typedef struct { int exp; longint scyc; } item_t;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  mont_mul16 u_mont_mul16 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mont_ref(input int a, input int b);
    return int'((longint'(a) * b % N) * rinv % N);
  endfunction

  // driver: start at negedge, push expected, wait for done (next start back to back)
  task automatic run_op(input int a, input int b);
    item_t it;
    @(negedge clk_i);
    start_i = 1'b1; a_i = W'(a); b_i = W'(b);
    it.exp = mont_ref(a, b); it.scyc = cyc;
    sb_q.push_back(it);
    @(negedge clk_i);
    start_i = 1'b0;
    @(posedge done_o);
  endtask

  // monitor
  logic         prev_done = 1'b0;
  logic [W-1:0] prev_res = '0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o) begin
        if (prev_done) check(0, "R3 double done", 1, 0);
        if (sb_q.size() == 0) check(0, "R4 unexpected done", 1, 0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          check(result_o == W'(it.exp), "R2/R6 result", result_o, it.exp);
          check(result_o < W'(N), "R7 range", result_o, N - 1);
          check(cyc == it.scyc + LAT, "R3 latency", cyc - it.scyc, LAT);
        end
      end else if (prev_res !== result_o) begin
        check(0, "R5 hold", result_o, prev_res);
      end
      prev_done = done_o;
      prev_res  = result_o;
    end
  end

  initial begin
    for (int r = 0; r < N; r++) if ((65536 * r) % N == 1) rinv = r;
    check(((N * NINV) % 65536) == 65535, "R8 constant", (N * NINV) % 65536, 65535);
    repeat (3) @(negedge clk_i);
    check(done_o == 1'b0 && result_o == '0, "R1 in reset", result_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(done_o == 1'b0 && result_o == '0, "R1 after reset", result_o, 0);
    // R6 boundaries
    run_op(0, 0); run_op(0, N - 1); run_op(N - 1, 0);
    run_op(1, 1); run_op(1, N - 1); run_op(N - 1, N - 1); run_op(N - 1, 1);
    // R9 back-to-back already exercised above; random set
    for (int i = 0; i < 30; i++) run_op(int'($urandom % N), int'($urandom % N));
    // R4 mid-operation start
    begin
      item_t it;
      @(negedge clk_i);
      start_i = 1'b1; a_i = 16'd7; b_i = 16'd9;
      it.exp = mont_ref(7, 9); it.scyc = cyc;
      sb_q.push_back(it);
      @(negedge clk_i); start_i = 1'b0;
      repeat (4) @(negedge clk_i);
      start_i = 1'b1; a_i = 16'd3; b_i = 16'd5;
      @(negedge clk_i); start_i = 1'b0; a_i = '0; b_i = '0;
      @(posedge done_o);
      repeat (30) @(negedge clk_i);
      check(sb_q.size() == 0, "R4 queue drained", sb_q.size(), 0);
    end
    run_op(2, 3);
    repeat (3) @(negedge clk_i);
    check(sb_q.size() == 0, "R9 final drain", sb_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule